// File: doc/BRIEF.md
# Digitally Trimmed Timekeeping Prescaler

This block turns a 32,768 Hz crystal clock into a one-cycle seconds tick. It corrects for crystal error without analog trimming. Instead it changes the divider count of selected seconds. The divider has two stages: a stage of PRE_DIV (256) clocks and a stage of POST_DIV (128) of those periods. A correction either splits one pulse at the 256-clock stage, which adds a count so the second ends early, or blanks half a pulse, which delays the second. A second-in-minute counter and a minute-in-cycle counter choose which seconds are corrected. The counters cover a repeating cycle of MIN_PER_CYCLE (64) minutes.

The calibration word is six bits wide. Bit 5 is the sign: 1 speeds the clock up and 0 slows it down. Bits 4:0 hold the magnitude. The word is sampled once per cycle, at the cycle boundary. The block has three more functions:
- A frequency-test output, a square wave at 512 Hz in the default setting. It runs whenever the test enable is set and the oscillator is running.
- An oscillator-stop input that freezes the divider.
- A century bit that flips on a rollover strobe when century counting is enabled.

The divider is a three-state machine:
- **LEAD** counts the first stage period of a second. It lasts PRE_DIV clocks, or 1.5·PRE_DIV clocks when the second is slowed.
- **RUN** counts the remaining stage periods.
- **HALT** holds all counters while the oscillator is stopped.

The transitions are:
- LEAD→RUN when the lead period ends. The post counter is then preset to 2 in a sped-up second and to 1 otherwise.
- RUN→LEAD on the last clock of the second.
- LEAD/RUN→HALT when osc_stop is high.
- HALT→LEAD if the post counter is zero, and HALT→RUN otherwise, once osc_stop falls.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: An uncorrected second lasts PRE_DIV·POST_DIV clocks (32,768 by default).
- R2: sec_tick is high for exactly one clock per second.
- R3: For a calibration word {sign = bit 5, magnitude = bits 4:0} with magnitude N, the first second of each of the first min(2N, MIN_PER_CYCLE−2) minutes of a cycle is corrected. No other second is corrected, and a magnitude of 0 corrects nothing.
- R4: A corrected second with sign 1 is shortened by PRE_DIV clocks (256 by default).
- R5: A corrected second with sign 0 is lengthened by PRE_DIV/2 clocks (128 by default).
- R6: The active calibration value is zero after reset and is reloaded from cal_word only at the end of the last second of a cycle. A change to cal_word in the middle of a cycle has no effect until the next cycle.
- R7: While osc_stop is 1, no tick is produced and the divider position is held. A second that contains a stop of K clocks lasts its normal length plus K+1 clocks.
- R8: With ft_en = 1 and osc_stop = 0, ft_out toggles every FT_HALF clocks (32, giving 512 Hz), whatever the calibration value. Otherwise ft_out is 0.
- R9: On a clock with cent_roll = 1 and cent_en = 1, cent_bit inverts. With cent_en = 0 it holds.
- R10: During reset, sec_tick, ft_out and cent_bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-down) |
| cal_word | input | 6 | Calibration: bit 5 sign, bits 4:0 magnitude |
| osc_stop | input | 1 | 1 halts the oscillator-driven chain |
| ft_en | input | 1 | Frequency-test enable |
| cent_en | input | 1 | Century counting enable |
| cent_roll | input | 1 | One-cycle century rollover strobe |
| sec_tick | output | 1 | One-cycle seconds tick |
| ft_out | output | 1 | Frequency-test square wave |
| cent_bit | output | 1 | Century flag |

## Verification
The bench runs the divider through five consecutive cycles, each with a different active calibration word:
- the zero value loaded at reset;
- a positive word of magnitude 1, which corrects two minutes;
- a negative word of magnitude 2, which corrects four minutes;
- a positive word of magnitude 31, which shows the cap at MIN_PER_CYCLE−2 minutes;
- a positive word of magnitude 0, which shows that the sign alone does nothing.

Together these separate the shortened seconds from the lengthened ones. They also show where the corrected minutes end. Each new word is written in the middle of the preceding cycle, so a design that applied it at once would mis-time the remaining seconds of that cycle. A stop inserted in the middle of a second checks the hold behaviour and the single re-entry clock. The frequency-test spacing is measured while the largest correction is active.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

    typedef enum logic [1:0] {
        S_LEAD = 2'd0,
        S_RUN  = 2'd1,
        S_HALT = 2'd2
    } div_state_e;

    typedef struct packed {
        logic       pos;
        logic [4:0] mag;
    } cal_t;

endpackage

// File: rtl/tsp_divider.sv
module tsp_divider
    import tsp_pkg::*;
#(
    parameter int PRE_DIV  = 256,
    parameter int POST_DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic corr_pos,
    input  logic corr_neg,
    output logic sec_end
);
    localparam int LEAD_EXT = PRE_DIV + PRE_DIV / 2;
    localparam int PW       = $clog2(LEAD_EXT);
    localparam int QW       = $clog2(POST_DIV);

    div_state_e    state_q, state_d;
    logic [PW-1:0] pre_q, pre_d;
    logic [QW-1:0] post_q, post_d;
    logic [PW-1:0] lead_term;

    // a slowed second stretches its first stage period by half
    assign lead_term = corr_neg ? PW'(LEAD_EXT - 1) : PW'(PRE_DIV - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_LEAD;
            pre_q   <= '0;
            post_q  <= '0;
        end else begin
            state_q <= state_d;
            pre_q   <= pre_d;
            post_q  <= post_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pre_d   = pre_q;
        post_d  = post_q;
        unique case (state_q)
            S_LEAD: begin
                if (!run) begin
                    state_d = S_HALT;
                end else if (pre_q == lead_term) begin
                    pre_d   = '0;
                    // a sped-up second counts the split pulse twice
                    post_d  = corr_pos ? QW'(2) : QW'(1);
                    state_d = S_RUN;
                end else begin
                    pre_d = pre_q + PW'(1);
                end
            end
            S_RUN: begin
                if (!run) begin
                    state_d = S_HALT;
                end else if (pre_q == PW'(PRE_DIV - 1)) begin
                    pre_d = '0;
                    if (post_q == QW'(POST_DIV - 1)) begin
                        post_d  = '0;
                        state_d = S_LEAD;
                    end else begin
                        post_d = post_q + QW'(1);
                    end
                end else begin
                    pre_d = pre_q + PW'(1);
                end
            end
            S_HALT: begin
                if (run) state_d = (post_q == '0) ? S_LEAD : S_RUN;
            end
            default: state_d = S_LEAD;
        endcase
    end

    always_comb begin
        sec_end = run && (state_q == S_RUN)
               && (pre_q == PW'(PRE_DIV - 1))
               && (post_q == QW'(POST_DIV - 1));
    end

    // R7
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(pre_q) && $stable(post_q)));

    // R5
    lead_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LEAD && !corr_neg) |-> (pre_q < PW'(PRE_DIV)));

endmodule

// File: rtl/tsp_cal_sched.sv
module tsp_cal_sched
    import tsp_pkg::*;
#(
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_end,
    input  cal_t cal_in,
    output logic corr_pos,
    output logic corr_neg
);
    localparam int SW   = $clog2(SEC_PER_MIN);
    localparam int MW   = $clog2(MIN_PER_CYCLE);
    localparam int ELIG = MIN_PER_CYCLE - 2;

    logic [SW-1:0] sec_q;
    logic [MW-1:0] min_q;
    cal_t          cal_q;
    logic          last_sec, last_min, wrap;
    logic [31:0]   span;
    logic          elig;

    assign last_sec = (sec_q == SW'(SEC_PER_MIN - 1));
    assign last_min = (min_q == MW'(MIN_PER_CYCLE - 1));
    assign wrap     = sec_end && last_sec && last_min;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= '0;
            min_q <= '0;
            cal_q <= '0;
        end else if (sec_end) begin
            if (last_sec) begin
                sec_q <= '0;
                if (last_min) begin
                    min_q <= '0;
                    cal_q <= cal_in;
                end else begin
                    min_q <= min_q + MW'(1);
                end
            end else begin
                sec_q <= sec_q + SW'(1);
            end
        end
    end

    always_comb begin
        span = {26'd0, cal_q.mag, 1'b0};
        if (span > 32'(ELIG)) span = 32'(ELIG);
        elig = (sec_q == '0) && ({{(32 - MW){1'b0}}, min_q} < span);
        corr_pos = elig && cal_q.pos;
        corr_neg = elig && !cal_q.pos;
    end

    // R6
    cal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(cal_q));

    // R3
    one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(corr_pos && corr_neg));

endmodule

// File: rtl/tsp_ftest.sv
module tsp_ftest #(
    parameter int FT_HALF = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ft_en,
    output logic wave
);
    localparam int FW = $clog2(FT_HALF);

    logic [FW-1:0] cnt_q;
    logic          wave_q;
    logic          active;

    assign active = ft_en && run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= (cnt_q == FW'(FT_HALF - 1)) ? '0 : cnt_q + FW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            wave_q <= 1'b0;
        else if (!active)                      wave_q <= 1'b0;
        else if (cnt_q == FW'(FT_HALF - 1))    wave_q <= !wave_q;
    end

    assign wave = wave_q;

    // R8
    ft_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ft_en && run) |=> !wave_q);

endmodule

// File: rtl/tsp_century.sv
module tsp_century (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic roll,
    output logic flag
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (en && roll) flag_q <= !flag_q;
    end

    assign flag = flag_q;

    // R9
    cent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && roll) |=> $stable(flag_q));

    // R9
    cent_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && roll) |=> (flag_q != $past(flag_q)));

endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
    import tsp_pkg::*;
#(
    parameter int PRE_DIV       = 256,
    parameter int POST_DIV      = 128,
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64,
    parameter int FT_HALF       = 32
) (
    input  logic       clk_osc,
    input  logic       rst_n,
    input  logic [5:0] cal_word,
    input  logic       osc_stop,
    input  logic       ft_en,
    input  logic       cent_en,
    input  logic       cent_roll,
    output logic       sec_tick,
    output logic       ft_out,
    output logic       cent_bit
);
    logic run;
    logic sec_end;
    logic corr_pos, corr_neg;
    cal_t cal_in;
    logic tick_q;

    assign run    = !osc_stop;
    assign cal_in = cal_t'(cal_word);

    tsp_divider #(
        .PRE_DIV  (PRE_DIV),
        .POST_DIV (POST_DIV)
    ) u_div (
        .clk      (clk_osc),
        .rst_n    (rst_n),
        .run      (run),
        .corr_pos (corr_pos),
        .corr_neg (corr_neg),
        .sec_end  (sec_end)
    );

    tsp_cal_sched #(
        .SEC_PER_MIN   (SEC_PER_MIN),
        .MIN_PER_CYCLE (MIN_PER_CYCLE)
    ) u_sched (
        .clk      (clk_osc),
        .rst_n    (rst_n),
        .sec_end  (sec_end),
        .cal_in   (cal_in),
        .corr_pos (corr_pos),
        .corr_neg (corr_neg)
    );

    tsp_ftest #(
        .FT_HALF (FT_HALF)
    ) u_ft (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .run   (run),
        .ft_en (ft_en),
        .wave  (ft_out)
    );

    tsp_century u_cent (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .en    (cent_en),
        .roll  (cent_roll),
        .flag  (cent_bit)
    );

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= sec_end;
    end

    assign sec_tick = tick_q;

    // R2
    tick_pulse_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    // R7
    stop_quiet_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
        osc_stop |=> !sec_tick);

endmodule

// File: tb/test_rtc_trim_prescaler.sv
module test_rtc_trim_prescaler;

    localparam int PRE  = 8;
    localparam int POST = 4;
    localparam int SPM  = 3;
    localparam int MPC  = 8;
    localparam int FTH  = 4;
    localparam int NOM  = PRE * POST;
    localparam int STOP_LEN = 10;
    localparam int LAST_TICK = 5 * SPM * MPC;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] cal_word;
    logic       osc_stop, ft_en, cent_en, cent_roll;
    logic       sec_tick, ft_out, cent_bit;

    always #10 clk = ~clk;

    rtc_trim_prescaler #(
        .PRE_DIV (PRE), .POST_DIV (POST), .SEC_PER_MIN (SPM),
        .MIN_PER_CYCLE (MPC), .FT_HALF (FTH)
    ) i_rtc_trim_prescaler (
        .clk_osc (clk), .rst_n (rst_n), .cal_word (cal_word),
        .osc_stop (osc_stop), .ft_en (ft_en), .cent_en (cent_en),
        .cent_roll (cent_roll), .sec_tick (sec_tick), .ft_out (ft_out),
        .cent_bit (cent_bit)
    );

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    int tick_n = 0;
    int gap    = 0;
    int e_len  = 0;
    bit prev_tick = 1'b0;
    bit done = 1'b0;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R3 R4 R5: expected second length from the correction schedule
    function automatic int sec_len(bit pos, int mag, int m, int s);
        int lim = 2 * mag;
        if (lim > MPC - 2) lim = MPC - 2;
        if (s == 0 && m < lim) return pos ? NOM - PRE : NOM + PRE / 2;
        return NOM;
    endfunction

    task automatic push_cycle(bit pos, int mag, int first);
        for (int m = 0; m < MPC; m++)
            for (int s = 0; s < SPM; s++)
                if (m * SPM + s >= first) exp_q.push_back(sec_len(pos, mag, m, s));
    endtask

    function automatic string tag_of(int len);
        if (len == NOM)           return "R1";
        if (len == NOM - PRE)     return "R4";
        if (len == NOM + PRE / 2) return "R5";
        return "R7";
    endfunction

    // monitor: measures each second and pops the expected length
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sec_tick) begin
                if (prev_tick) check("R2", 2, 1);
                if (tick_n > 0) begin
                    if (exp_q.size() == 0) begin
                        check("R6", gap + 1, 0);
                    end else begin
                        e_len = exp_q.pop_front();
                        check(tag_of(e_len), gap + 1, e_len);
                    end
                end
                tick_n++;
                gap = 0;
            end else begin
                gap++;
            end
            prev_tick = sec_tick;
        end
    end

    task automatic ft_measure();
        logic last;
        int   n;
        ft_en = 1'b1;
        last = ft_out;
        for (int i = 0; i < 50 && ft_out == last; i++) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            last = ft_out;
            n = 0;
            for (int i = 0; i < 50 && ft_out == last; i++) begin
                @(negedge clk);
                n++;
            end
            // R8 spacing unaffected by the active maximum correction
            check("R8", n, FTH);
        end
        ft_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R8", ft_out, 0);
    endtask

    initial begin
        int ones, ft_ones;
        rst_n = 1'b0;
        cal_word = 6'b100001;
        osc_stop = 1'b0; ft_en = 1'b0; cent_en = 1'b0; cent_roll = 1'b0;
        // R6: cycle 0 runs uncorrected; each later word is written mid-cycle
        push_cycle(1'b0, 0, 1);
        push_cycle(1'b1, 1, 0);
        push_cycle(1'b0, 2, 0);
        push_cycle(1'b1, 31, 0);
        push_cycle(1'b1, 0, 0);
        exp_q[99] += STOP_LEN + 1;

        repeat (3) @(negedge clk);
        check("R10", sec_tick, 0);
        check("R10", ft_out, 0);
        check("R10", cent_bit, 0);
        rst_n = 1'b1;

        cent_roll = 1'b1;
        @(negedge clk) cent_roll = 1'b0;
        @(negedge clk);
        check("R9", cent_bit, 0);
        cent_en = 1'b1; cent_roll = 1'b1;
        @(negedge clk) cent_roll = 1'b0;
        check("R9", cent_bit, 1);
        cent_roll = 1'b1;
        @(negedge clk) cent_roll = 1'b0;
        check("R9", cent_bit, 0);
        repeat (4) @(negedge clk);
        check("R9", cent_bit, 0);

        ones = 0;
        repeat (12) begin
            @(negedge clk);
            ones += int'(ft_out);
        end
        check("R8", ones, 0);

        wait (tick_n == 36);
        cal_word = 6'b000010;
        wait (tick_n == 60);
        cal_word = 6'b111111;
        wait (tick_n == 80);
        ft_measure();
        wait (tick_n == 84);
        cal_word = 6'b100000;

        wait (tick_n == 100);
        repeat (5) @(negedge clk);
        ft_en = 1'b1;
        osc_stop = 1'b1;
        ones = 0; ft_ones = 0;
        repeat (STOP_LEN) begin
            @(negedge clk);
            ones += int'(sec_tick);
            ft_ones += int'(ft_out);
        end
        osc_stop = 1'b0;
        ft_en = 1'b0;
        check("R7", ones, 0);
        check("R8", ft_ones, 0);

        wait (tick_n == LAST_TICK);
        repeat (4) @(negedge clk);
        check("R6", exp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=%0d ticks expected=%0d ticks", tick_n, LAST_TICK);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule